// File: doc/BRIEF.md
# Configurable Watchdog Timer

This block supervises firmware with a single counter that moves by one on every clock while the watchdog is running. The counter can run in either direction. Counting down, it expires on reaching zero and reloads from a stored timeout. Counting up, it expires on reaching its all-ones value and restarts from zero. Firmware loads the count and starts the timer through a two-entry register interface. It must then service the timer before the counter reaches its terminal value.

Expiry has one of two effects, chosen by a configuration bit. The first is a reset pulse of a fixed, parameterised width, during which the counter is frozen. The second is a level interrupt that stays high until firmware acknowledges it. In both cases a sticky status bit records that the watchdog fired. Once the timer is enabled, it cannot be disabled and its configuration cannot be changed; only the system reset releases it.

Register map. Address 0 is the control and status register:
- bit 0: run (set only)
- bit 1: direction, 1 = up
- bit 2: interrupt select, 1 = interrupt
- bit 3: service strobe, reads 0
- bit 4: expiry flag, write 1 to clear

Address 1 is the count register. Writing it loads the counter and the down-count timeout. Reading it returns the live count.

Top module: `wdt_core`

## Requirements
- R1: After rst_n is low, both registers read 0 and wdt_rst_o and irq_o are low.
- R2: While run is set and no pulse is active, the count changes by exactly one each clock: down when bit 1 is 0, up when bit 1 is 1. While run is clear, the count holds.
- R3: In down mode, a clock edge at which the count is 0 is an expiry. The counter reloads with the timeout value and bit 4 sets.
- R4: In up mode, a clock edge at which the count is all ones is an expiry. The counter reloads with 0 and bit 4 sets.
- R5: Writing 1 to bit 3 of address 0 reloads the counter: with the timeout in down mode, with 0 in up mode. On a terminal-count edge, this write suppresses the expiry.
- R6: With bit 2 clear, an expiry drives wdt_rst_o high for exactly RST_CYC cycles, starting the cycle after the terminal edge. The counter holds during the pulse and resumes counting on the edge after the pulse ends.
- R7: With bit 2 set, an expiry raises irq_o in the cycle after the terminal edge and produces no reset pulse. irq_o stays high until bit 4 is cleared.
- R8: Bit 4 is sticky and is cleared by writing 1 to it. When an expiry and a clear fall on the same edge, the bit ends up set.
- R9: Once bit 0 is set, writing 0 to it has no effect.
- R10: Once bit 0 is set, writes to bits 1 and 2 are ignored. The write that sets bit 0 may still set them.
- R11: A write to address 1 loads the counter with the written value and records it as the down-count timeout, whether or not the timer is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 control/status, 1 count |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data of the selected register |
| wdt_rst_o | output | 1 | Watchdog reset pulse |
| irq_o | output | 1 | Watchdog interrupt, level |

## Verification
The hardest situations to reach are the ones where firmware activity lands on exactly the terminal-count edge: a service strobe that must beat the expiry, and a flag clear that must lose to it. The stimulus loads the count register with the all-ones value while the timer runs up. The very next write then samples at the terminal edge, so the collision occurs deterministically without waiting out a full period. A behavioural reference model, run alongside, covers every other cycle, including the frozen counter during the reset pulse.

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int CNT_W   = 16,
  parameter int RST_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             wdt_rst_o,
  output logic             irq_o
);
  localparam int RC_W = $clog2(RST_CYC + 1);
  localparam logic [CNT_W-1:0] TERM_UP = '1;

  logic [CNT_W-1:0] cnt, tmo;
  logic             en, dir, irq_sel, flag;
  logic [RC_W-1:0]  rc;

  wire ctl_wr  = wr_en && !addr;
  wire cnt_wr  = wr_en && addr;
  wire svc     = ctl_wr && wdata[3];
  wire run     = en && (rc == '0);
  wire at_term = dir ? (cnt == TERM_UP) : (cnt == '0);
  wire expire  = run && at_term && !svc && !cnt_wr;
  wire [CNT_W-1:0] reload = dir ? '0 : tmo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      tmo <= '0;
    end else if (cnt_wr) begin
      cnt <= wdata;
      tmo <= wdata;
    end else if (svc || expire) begin
      cnt <= reload;
    end else if (run) begin
      cnt <= dir ? cnt + 1'b1 : cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en      <= 1'b0;
      dir     <= 1'b0;
      irq_sel <= 1'b0;
    end else if (ctl_wr) begin
      en <= en | wdata[0];
      if (!en) begin
        dir     <= wdata[1];
        irq_sel <= wdata[2];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      flag <= 1'b0;
    else if (expire)
      flag <= 1'b1;
    else if (ctl_wr && wdata[4])
      flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rc <= '0;
    else if (expire && !irq_sel)
      rc <= RC_W'(RST_CYC);
    else if (rc != '0)
      rc <= rc - 1'b1;
  end

  assign wdt_rst_o = (rc != '0);
  assign irq_o     = flag && irq_sel;
  assign rdata     = addr ? cnt : CNT_W'({flag, 1'b0, irq_sel, dir, en});
endmodule

// File: rtl/wdt_core_chk.sv
module wdt_core_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             en,
  input logic             dir,
  input logic             irq_sel,
  input logic             flag,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] tmo,
  input logic             wdt_rst_o
);
  localparam logic [CNT_W-1:0] ALL1 = '1;

  a_r9_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en);

  a_r10_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ($stable(dir) && $stable(irq_sel)));

  a_r6_hold_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_rst_o && !wr_en) |=> $stable(cnt));

  a_r7_no_pulse_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq_sel |-> !wdt_rst_o);

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wdt_rst_o && !wr_en && !dir && cnt != '0)
      |=> cnt == CNT_W'($past(cnt) - 1'b1));

  a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wdt_rst_o && !wr_en && dir && cnt != ALL1)
      |=> cnt == CNT_W'($past(cnt) + 1'b1));

  a_r3_down_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !dir && !wdt_rst_o && !wr_en && cnt == '0)
      |=> (cnt == tmo && flag));

  a_r4_up_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dir && !wdt_rst_o && !wr_en && cnt == ALL1)
      |=> (cnt == '0 && flag));
endmodule

bind wdt_core wdt_core_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .en(en), .dir(dir),
  .irq_sel(irq_sel), .flag(flag), .cnt(cnt), .tmo(tmo),
  .wdt_rst_o(wdt_rst_o)
);

// File: tb/wdt_core_tb_top.sv
module wdt_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int RST_CYC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic addr = 1'b0;
  logic [CNT_W-1:0] wdata = '0;
  logic [CNT_W-1:0] rdata;
  logic wdt_rst_o, irq_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_core #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .wdt_rst_o(wdt_rst_o), .irq_o(irq_o)
  );

  // reference model
  int m_cnt, m_tmo, m_rc;
  bit m_en, m_dir, m_irq, m_flag;
  localparam int MAXV = (1 << CNT_W) - 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_tmo = 0; m_rc = 0;
      m_en = 0; m_dir = 0; m_irq = 0; m_flag = 0;
    end else begin
      bit cw, kw, sv, term, ex;
      cw = wr_en && !addr;
      kw = wr_en && addr;
      sv = cw && wdata[3];
      term = m_en && m_rc == 0 && (m_dir ? m_cnt == MAXV : m_cnt == 0);
      ex = term && !sv && !kw;
      if (kw) begin m_cnt = wdata; m_tmo = wdata; end
      else if (sv || ex) m_cnt = m_dir ? 0 : m_tmo;
      else if (m_en && m_rc == 0) m_cnt = m_dir ? (m_cnt + 1) % (MAXV + 1)
                                                 : (m_cnt + MAXV) % (MAXV + 1);
      if (ex && !m_irq) m_rc = RST_CYC;
      else if (m_rc != 0) m_rc = m_rc - 1;
      if (ex) m_flag = 1;
      else if (cw && wdata[4]) m_flag = 0;
      if (cw) begin
        if (!m_en) begin m_dir = wdata[1]; m_irq = wdata[2]; end
        m_en = m_en | wdata[0];
      end
    end
  end

  function automatic int m_read(bit a);
    return a ? m_cnt : {m_flag, 1'b0, m_irq, m_dir, m_en};
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check("model rdata", rdata, m_read(addr));
      check("model wdt_rst_o", wdt_rst_o, m_rc != 0);
      check("model irq_o", irq_o, m_flag && m_irq);
    end
  end

  task automatic wr(bit a, int d);
    wr_en = 1'b1; addr = a; wdata = CNT_W'(d);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(bit a, output int v);
    addr = a; #1; v = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
  endtask

  initial begin
    int v;
    idle(2);
    rst_n = 1'b1;
    // R1 reset state
    rd(0, v); check("R1 ctrl", v, 0);
    rd(1, v); check("R1 count", v, 0);
    check("R1 rst", wdt_rst_o, 0);
    check("R1 irq", irq_o, 0);

    // R11 load while stopped, R2 hold while stopped
    wr(1, 5);
    rd(1, v); check("R11 load", v, 5);
    idle(3);
    rd(1, v); check("R2 hold when stopped", v, 5);

    // down, interrupt mode
    wr(0, 5'b00101);
    rd(1, v); check("R2 first edge", v, 5);
    idle(2);
    rd(1, v); check("R2 down step", v, 3);
    idle(3);
    rd(1, v); check("R3 reached zero", v, 0);
    check("R7 irq before expiry", irq_o, 0);
    idle(1);
    rd(1, v); check("R3 reload timeout", v, 5);
    check("R7 irq raised", irq_o, 1);
    check("R7 no reset pulse", wdt_rst_o, 0);
    rd(0, v); check("R3 flag set", v[4], 1);
    idle(1);
    check("R7 irq held", irq_o, 1);

    // R9, R10 locks
    wr(0, 5'b00010);
    rd(0, v); check("R9 run stays set", v[0], 1);
    check("R10 dir locked", v[1], 0);
    check("R10 irq sel locked", v[2], 1);

    // R8 clear
    wr(0, 5'b10000);
    rd(0, v); check("R8 flag cleared", v[4], 0);
    check("R7 irq dropped", irq_o, 0);

    // R5 down service
    idle(1);
    wr(0, 5'b01000);
    rd(1, v); check("R5 down service reload", v, 5);

    // R11 load while running
    wr(1, 9);
    rd(1, v); check("R11 load running", v, 9);

    // up, reset mode
    do_reset();
    wr(1, 250);
    wr(0, 5'b00011);
    idle(5);
    rd(1, v); check("R4 reach max", v, 255);
    check("R6 no pulse yet", wdt_rst_o, 0);
    idle(1);
    rd(1, v); check("R4 reload zero", v, 0);
    check("R6 pulse start", wdt_rst_o, 1);
    check("R7 no irq in reset mode", irq_o, 0);
    rd(0, v); check("R4 flag set", v[4], 1);
    idle(2);
    check("R6 pulse last cycle", wdt_rst_o, 1);
    rd(1, v); check("R6 count frozen", v, 0);
    idle(1);
    check("R6 pulse ended", wdt_rst_o, 0);
    rd(1, v); check("R6 still frozen at end", v, 0);
    idle(1);
    rd(1, v); check("R6 resumed", v, 1);

    // R10: lock in other direction
    wr(0, 5'b00101);
    rd(0, v); check("R10 dir kept up", v[1], 1);
    check("R10 irq kept off", v[2], 0);

    // R5 up service on terminal edge
    wr(0, 5'b10011);
    wr(1, 255);
    wr(0, 5'b01011);
    rd(1, v); check("R5 up service reload", v, 0);
    check("R5 expiry suppressed", wdt_rst_o, 0);
    rd(0, v); check("R5 no flag", v[4], 0);
    idle(1);
    check("R5 no late pulse", wdt_rst_o, 0);

    // R8 set wins over clear
    wr(1, 255);
    wr(0, 5'b10011);
    rd(0, v); check("R8 set beats clear", v[4], 1);
    check("R6 pulse on collision", wdt_rst_o, 1);
    idle(5);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule